// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block sits between a 32-bit register bus and the serial shift engine of an SPI master. Software programs two control words, reads a status word and moves data through two four-entry queues. Each transmit entry is 32 bits plus one tag bit. The tag tells the shift engine whether chip select stays asserted after the entry (the hold port) or is released after it (the data port). Received words come back through the data port, which pops the queue. A separate peek address returns the oldest received word and leaves it in the queue.

The engine pulls transmit entries over a valid/ready handshake and pushes received words with a valid strobe. It also reports whether it is busy. A level interrupt can be raised when the transmit queue drains, or when the queue is empty and the engine is idle. The timing of the serial lines is not part of this block.

Top module: `spi_regfront`

## Requirements
- R1: After reset both control words read as zero, status reads 0x0000_0280 (both queues empty), `irq` is low and `tx_valid` is low.
- R2: Control word 0 (offset 0x00) and control word 1 (offset 0x04) read back what was written, except bit 9 of control word 0, which always reads as 0. Both words appear on `ctl0_o` and `ctl1_o`.
- R3: A write to offset 0x00 with bit 9 set empties both queues in that cycle. Entries waiting in the queues are discarded.
- R4: A write to offset 0x20 queues the word with tag 0 (release chip select). A write to offset 0x30 queues it with tag 1 (hold chip select). Entries leave in write order, one on each cycle where `tx_valid` and `tx_ready` are both high.
- R5: The transmit queue holds 4 entries. A data write while it is full is ignored, even if the engine takes an entry in that same cycle.
- R6: A read of offset 0x20 returns the oldest received word and removes it. A read of offset 0x0C returns the same word and leaves the queue unchanged. Read data appears on `bus_rdata` from the clock edge that accepts the read.
- R7: A read of offset 0x20 or 0x0C while the receive queue is empty returns zero and changes no level.
- R8: The receive queue holds 4 entries. A word that arrives while it is full is dropped, and the full flag stays set. `rx_ready` is low while the queue is full.
- R9: Status (offset 0x08) packs these fields:
  - bits 31:24: transmit level
  - bits 23:16: receive level
  - bit 10: transmit full
  - bit 9: transmit empty
  - bit 8: receive full
  - bit 7: receive empty
  - bit 6: engine busy
  - all other bits: 0
- R10: `irq` = (ctl1 bit 7 AND transmit empty) OR (ctl1 bit 6 AND NOT busy AND transmit empty). Writing zero to control word 1 lowers it.
- R11: When a queue is pushed and popped in the same cycle, both actions take effect, so its level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Engine takes the entry |
| tx_data | output | 32 | Transmit entry word |
| tx_keep_cs | output | 1 | Entry tag: 1 = hold chip select after it |
| rx_valid | input | 1 | Engine delivers a received word |
| rx_data | input | 32 | Received word |
| rx_ready | output | 1 | Receive queue has room |
| eng_busy | input | 1 | Engine is shifting |
| ctl0_o | output | 32 | Control word 0 to the engine |
| ctl1_o | output | 32 | Control word 1 to the engine |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can fall in the same clock cycle. A bus data write can land in the cycle where the engine takes a transmit entry. A bus pop of the data port can land in the cycle where the engine delivers a received word. The bench sets both up on one falling edge, with two entries already queued on the transmit side and one on the receive side. It then checks three things: the scoreboard sees the oldest transmit entry leave, the read returns the older received word, and the status levels are unchanged. A transmit write issued while the queue is full is also checked to vanish, with no entry reaching the scoreboard for it.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int LVL_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTL0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PEEK = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_HOLD = 8'h30;

    localparam int C0_FLUSH_BIT = 9;
    localparam int C1_TXE_IE    = 7;
    localparam int C1_IDLE_IE   = 6;

    localparam int ST_TX_FULL  = 10;
    localparam int ST_TX_EMPTY = 9;
    localparam int ST_RX_FULL  = 8;
    localparam int ST_RX_EMPTY = 7;
    localparam int ST_BUSY     = 6;

    typedef struct packed {
        logic [BUS_W-1:0] ctl0;
        logic [BUS_W-1:0] ctl1;
        logic [BUS_W-1:0] rdata;
    } fe_regs_t;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [LW-1:0]           wptr;
        logic [LW-1:0]           rptr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    assign level = st_q.wptr - st_q.rptr;
    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign dout  = st_q.mem[st_q.rptr[AW-1:0]];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
        end else begin
            if (push && !full) begin
                st_d.mem[st_q.wptr[AW-1:0]] = din;
                st_d.wptr = st_q.wptr + 1'b1;
            end
            if (pop && !empty) begin
                st_d.rptr = st_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5 R8: a push into a full queue leaves it full
    assert_full_push_dropped_R5_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    // R5 R8: the level never goes past the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R7: popping an empty queue keeps it empty
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);
    // R11: a push and a pop in one cycle keep the level
    assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !flush) |=> $stable(level));
endmodule

// File: rtl/spi_fe_stat.sv
module spi_fe_stat
    import spi_fe_pkg::*;
#(
    parameter int TX_LW = 3,
    parameter int RX_LW = 3
) (
    input  logic [TX_LW-1:0] tx_level,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic [RX_LW-1:0] rx_level,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             busy,
    input  logic [BUS_W-1:0] ctl1,
    output logic [BUS_W-1:0] status,
    output logic             irq
);
    always_comb begin
        status                 = '0;
        status[31:24]          = LVL_W'(tx_level);
        status[23:16]          = LVL_W'(rx_level);
        status[ST_TX_FULL]     = tx_full;
        status[ST_TX_EMPTY]    = tx_empty;
        status[ST_RX_FULL]     = rx_full;
        status[ST_RX_EMPTY]    = rx_empty;
        status[ST_BUSY]        = busy;
    end

    assign irq = (ctl1[C1_TXE_IE] & tx_empty) |
                 (ctl1[C1_IDLE_IE] & ~busy & tx_empty);
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_fe_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BUS_W-1:0]  tx_data,
    output logic              tx_keep_cs,
    input  logic              rx_valid,
    input  logic [BUS_W-1:0]  rx_data,
    output logic              rx_ready,
    input  logic              eng_busy,
    output logic [BUS_W-1:0]  ctl0_o,
    output logic [BUS_W-1:0]  ctl1_o,
    output logic              irq
);
    localparam int TX_LW = $clog2(TX_DEPTH) + 1;
    localparam int RX_LW = $clog2(RX_DEPTH) + 1;
    localparam int TX_W  = BUS_W + 1;

    fe_regs_t regs_d, regs_q;

    logic             flush;
    logic             tx_push, tx_pop, tx_tag;
    logic [TX_W-1:0]  tx_head;
    logic [TX_LW-1:0] tx_level;
    logic             tx_full, tx_empty;
    logic             rx_pop;
    logic [BUS_W-1:0] rx_head;
    logic [RX_LW-1:0] rx_level;
    logic             rx_full, rx_empty;
    logic [BUS_W-1:0] status;

    wire bus_wen = bus_sel & bus_wr;
    wire bus_ren = bus_sel & ~bus_wr;

    always_comb begin
        regs_d  = regs_q;
        flush   = 1'b0;
        tx_push = 1'b0;
        tx_tag  = 1'b0;
        rx_pop  = 1'b0;
        if (bus_wen) begin
            unique case (bus_addr)
                OFS_CTL0: begin
                    regs_d.ctl0               = bus_wdata;
                    regs_d.ctl0[C0_FLUSH_BIT] = 1'b0;
                    flush                     = bus_wdata[C0_FLUSH_BIT];
                end
                OFS_CTL1: regs_d.ctl1 = bus_wdata;
                OFS_DATA: tx_push = 1'b1;
                OFS_HOLD: begin
                    tx_push = 1'b1;
                    tx_tag  = 1'b1;
                end
                default: ;
            endcase
        end
        if (bus_ren) begin
            unique case (bus_addr)
                OFS_CTL0: regs_d.rdata = regs_q.ctl0;
                OFS_CTL1: regs_d.rdata = regs_q.ctl1;
                OFS_STAT: regs_d.rdata = status;
                OFS_PEEK: regs_d.rdata = rx_empty ? '0 : rx_head;
                OFS_DATA: begin
                    regs_d.rdata = rx_empty ? '0 : rx_head;
                    rx_pop       = ~rx_empty;
                end
                default:  regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign tx_pop = tx_valid & tx_ready;

    spi_fe_fifo #(.W(TX_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (tx_push),
        .din   ({tx_tag, bus_wdata}),
        .pop   (tx_pop),
        .dout  (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fe_fifo #(.W(BUS_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_valid),
        .din   (rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_fe_stat #(.TX_LW(TX_LW), .RX_LW(RX_LW)) i_stat (
        .tx_level (tx_level),
        .tx_full  (tx_full),
        .tx_empty (tx_empty),
        .rx_level (rx_level),
        .rx_full  (rx_full),
        .rx_empty (rx_empty),
        .busy     (eng_busy),
        .ctl1     (regs_q.ctl1),
        .status   (status),
        .irq      (irq)
    );

    assign bus_rdata  = regs_q.rdata;
    assign tx_valid   = ~tx_empty;
    assign tx_data    = tx_head[BUS_W-1:0];
    assign tx_keep_cs = tx_head[BUS_W];
    assign rx_ready   = ~rx_full;
    assign ctl0_o     = regs_q.ctl0;
    assign ctl1_o     = regs_q.ctl1;

    // R10: the interrupt only rises with an empty transmit queue
    assert_irq_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !tx_valid);
    // R3: a flush write leaves both queues empty
    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_CTL0 && bus_wdata[C0_FLUSH_BIT]) |=> (!tx_valid && rx_ready));
    // R2: the flush bit never sticks
    assert_flush_not_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_o[C0_FLUSH_BIT]);
    // R7: a data-port read of an empty receive queue returns zero
    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && bus_addr == OFS_DATA && rx_empty) |=> (bus_rdata == '0));
endmodule

// File: tb/test_spi_regfront.sv
module test_spi_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_keep_cs, rx_ready, irq;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        eng_busy = 1'b0;
    logic [31:0] ctl0_o, ctl1_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [32:0] exp_tx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfront i_spi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_keep_cs(tx_keep_cs), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .eng_busy(eng_busy), .ctl0_o(ctl0_o),
        .ctl1_o(ctl1_o), .irq(irq)
    );

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, {1'b0, v}, {1'b0, exp});
    endtask

    // driver: queue an entry and tell the scoreboard what must leave
    task automatic push_tx(input bit hold, input logic [31:0] d);
        exp_tx.push_back({hold, d});
        bus_write(hold ? 8'h30 : 8'h20, d);
    endtask

    task automatic push_rx(input logic [31:0] d);
        @(negedge clk);
        rx_valid = 1; rx_data = d;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic drain_tx();
        @(negedge clk);
        tx_ready = 1;
        repeat (6) @(negedge clk);
        tx_ready = 0;
    endtask

    // monitor: compare each entry the engine takes (R4)
    always @(negedge clk) begin
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                chk("R4 unexpected entry", {tx_keep_cs, tx_data}, 33'h0);
                if ({tx_keep_cs, tx_data} == 33'h0) begin
                    errors++;
                    $display("FAIL R4: actual extra entry expected none");
                end
            end else begin
                chk("R4 order/tag", {tx_keep_cs, tx_data}, exp_tx.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        read_chk("R1 ctl0", 8'h00, 32'h0);
        read_chk("R1 ctl1", 8'h04, 32'h0);
        read_chk("R1 status", 8'h08, 32'h0000_0280);
        chk("R1 irq", {32'h0, irq}, 33'h0);
        chk("R1 tx_valid", {32'h0, tx_valid}, 33'h0);

        // R2 control readback, flush bit not kept
        bus_write(8'h00, 32'hABC0_0A40);
        read_chk("R2 ctl0", 8'h00, 32'hABC0_0840);
        chk("R2 ctl0_o", {1'b0, ctl0_o}, {1'b0, 32'hABC0_0840});
        bus_write(8'h04, 32'h0000_0003);
        read_chk("R2 ctl1", 8'h04, 32'h0000_0003);

        // R4 R9 three entries with tags
        push_tx(0, 32'h1811_2233);
        push_tx(1, 32'h1844_5566);
        push_tx(0, 32'h0877_0000);
        read_chk("R9 status tx3", 8'h08, 32'h0300_0080);
        drain_tx();
        chk("R4 all taken", 33'(exp_tx.size()), 33'h0);

        // R5 fifth write to full queue ignored
        push_tx(1, 32'h0000_0001);
        push_tx(0, 32'h0000_0002);
        push_tx(1, 32'h0000_0003);
        push_tx(0, 32'h0000_0004);
        bus_write(8'h20, 32'hDEAD_BEEF);
        read_chk("R5 status full", 8'h08, 32'h0400_0480);
        drain_tx();
        chk("R5 nothing extra", 33'(exp_tx.size()), 33'h0);

        // R6 R7 receive pop and peek
        push_rx(32'hA000_0001);
        push_rx(32'hA000_0002);
        push_rx(32'hA000_0003);
        read_chk("R6 peek", 8'h0C, 32'hA000_0001);
        read_chk("R6 peek again", 8'h0C, 32'hA000_0001);
        read_chk("R9 status rx3", 8'h08, 32'h0003_0200);
        read_chk("R6 pop1", 8'h20, 32'hA000_0001);
        read_chk("R6 pop2", 8'h20, 32'hA000_0002);
        read_chk("R6 pop3", 8'h20, 32'hA000_0003);
        read_chk("R7 empty pop", 8'h20, 32'h0);
        read_chk("R7 empty peek", 8'h0C, 32'h0);
        read_chk("R7 status", 8'h08, 32'h0000_0280);

        // R8 overflow dropped
        for (int i = 0; i < 5; i++) push_rx(32'hD000_0000 + 32'(i));
        chk("R8 rx_ready low", {32'h0, rx_ready}, 33'h0);
        read_chk("R8 status full", 8'h08, 32'h0004_0300);
        for (int i = 0; i < 4; i++) read_chk("R8 pop", 8'h20, 32'hD000_0000 + 32'(i));
        read_chk("R8 fifth dropped", 8'h20, 32'h0);

        // R3 flush
        push_tx(0, 32'h1111_1111);
        push_tx(1, 32'h2222_2222);
        push_rx(32'h3333_3333);
        push_rx(32'h4444_4444);
        bus_write(8'h00, 32'h0000_0200);
        exp_tx.delete();
        read_chk("R3 status", 8'h08, 32'h0000_0280);
        read_chk("R3 ctl0", 8'h00, 32'h0);

        // R10 interrupt
        bus_write(8'h04, 32'h0000_0080);
        chk("R10 txe irq", {32'h0, irq}, 33'h1);
        push_tx(0, 32'h5555_0000);
        chk("R10 txe irq busy queue", {32'h0, irq}, 33'h0);
        drain_tx();
        bus_write(8'h04, 32'h0000_0040);
        @(negedge clk); eng_busy = 1;
        #1 chk("R10 idle irq busy", {32'h0, irq}, 33'h0);
        read_chk("R9 busy bit", 8'h08, 32'h0000_02C0);
        @(negedge clk); eng_busy = 0;
        #1 chk("R10 idle irq", {32'h0, irq}, 33'h1);
        bus_write(8'h04, 32'h0);
        chk("R10 disabled", {32'h0, irq}, 33'h0);

        // R11 same-cycle push and pop, transmit side
        push_tx(0, 32'hE000_0001);
        push_tx(1, 32'hE000_0002);
        exp_tx.push_back({1'b0, 32'hE000_0003});
        @(negedge clk);
        tx_ready = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'hE000_0003;
        @(negedge clk);
        tx_ready = 0; bus_sel = 0; bus_wr = 0;
        chk("R11 one taken", 33'(exp_tx.size()), 33'h2);
        read_chk("R11 tx level kept", 8'h08, 32'h0200_0080);
        drain_tx();
        chk("R11 drained", 33'(exp_tx.size()), 33'h0);

        // R11 same-cycle push and pop, receive side
        push_rx(32'hC000_0001);
        @(negedge clk);
        rx_valid = 1; rx_data = 32'hC000_0002; bus_sel = 1; bus_wr = 0; bus_addr = 8'h20;
        @(negedge clk);
        rx_valid = 0; bus_sel = 0;
        chk("R11 rx pop old", {1'b0, bus_rdata}, {1'b0, 32'hC000_0001});
        read_chk("R11 rx level kept", 8'h08, 32'h0001_0200);
        read_chk("R11 rx new", 8'h20, 32'hC000_0002);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule